// File: doc/BRIEF.md
# Transmit Descriptor Ownership Controller

This block decides when the transmit DMA may use a descriptor in a ring that it shares with the host. On a start command it reads the first word of the current descriptor and checks the ownership bit. If the DMA owns the descriptor, the block signals the frame engine to send the frame. If the host owns it, the block parks in a suspended state and sets a sticky flag. Software hands the descriptor back to the DMA by setting the ownership bit, then issues a poll demand, and fetching resumes from the same address.

When the frame engine reports completion, the block writes status back into the first word with ownership returned to the host. It then steps to the next ring entry, wrapping to the base after the last one, and fetches again. A jabber abort closes the descriptor with an error bit set and halts the block. A stop command takes effect at the next descriptor boundary.

The block reports its process state as a 3-bit code. Three sticky event flags, which software clears by writing a one, record completion, buffer-unavailable and stop events.

Top module: `txdesc_owner_ctrl`

## Requirements
- R1: After reset the process state is 0 (Stopped), all event flags are 0, no memory request is active, and the descriptor address equals the ring base.
- R2: A start command in Stopped issues a read of the first word at the current descriptor address. A start command in any other state has no effect.
- R3: When a fetched word has bit 31 = 1 (DMA owns it), the state becomes 2 (Waiting) and frame_go pulses for exactly one cycle per fetched descriptor.
- R4: When a fetched word has bit 31 = 0 (host owns it), the state becomes 6 (Suspended) and event flag bit 1 (buffer unavailable) is set.
- R5: A poll demand in Suspended re-reads the descriptor at the same address. A poll demand in any other state is ignored.
- R6: On frame done the block writes the first word with bit 31 = 0, bit 30 = 0, bits 15:0 = frame status and all other bits 0. It then sets event flag bit 0 (complete) and fetches the next descriptor.
- R7: After each write-back the address advances by the stride (16). After the last of the 4 entries it wraps to the ring base.
- R8: A jabber abort while Waiting writes the first word with bit 30 = 1 and bits 15:0 = 0, advances the address, moves to state 0, and sets event flag bit 2 (stopped) without setting bit 0.
- R9: A stop command in Suspended moves to Stopped at once. A stop command while a frame is in flight is held until that descriptor's write-back completes, and then the block moves to Stopped instead of fetching. Both paths set event flag bit 2.
- R10: Writing a 1 to an event-flag clear bit clears that flag, and writing a 0 leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R11: The state code takes only the values 0, 1, 2, 3 and 6. A memory request stays asserted, with stable address and direction, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start the transmit process (one-cycle pulse) |
| cmd_stop | input | 1 | Stop at the next descriptor boundary |
| cmd_poll | input | 1 | Poll demand, resumes a suspended process |
| jab_abort | input | 1 | Abort from the jabber watchdog |
| frame_done | input | 1 | Frame engine finished the current frame |
| frame_stat | input | 16 | Frame status to write back |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Descriptor address |
| mem_wdata | output | 32 | Write-back word |
| mem_ack | input | 1 | Request accepted (read data valid) |
| mem_rdata | input | 32 | First descriptor word |
| frame_go | output | 1 | One-cycle pulse that lets the frame engine send |
| proc_state | output | 3 | Process state code |
| evt_flags | output | 3 | Sticky flags: bit 0 complete, bit 1 unavailable, bit 2 stopped |
| evt_clr | input | 3 | Write-one-to-clear strobes for evt_flags |

## Verification
A wrong state would show at proc_state on the next clock. It would also show within one or two cycles as a missing or extra memory request, or a write-back word with the wrong ownership or error bit. A corrupted ring pointer shows as a wrong mem_addr on the next fetch or write-back, and the scoreboard catches it by comparing every write-back address and word. Lost or phantom event flags show one cycle after the transition that should set them.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
    localparam int DW      = 32;
    localparam int OWN_BIT = 31;
    localparam int ERR_BIT = 30;

    localparam int EVT_N       = 3;
    localparam int EVT_DONE    = 0;
    localparam int EVT_UNAVAIL = 1;
    localparam int EVT_STOPPED = 2;

    typedef enum logic [2:0] {
        TX_STOPPED = 3'd0,
        TX_FETCH   = 3'd1,
        TX_WAIT    = 3'd2,
        TX_CLOSE   = 3'd3,
        TX_SUSPEND = 3'd6
    } tx_state_e;
endpackage

// File: rtl/txdesc_ring_ptr.sv
module txdesc_ring_ptr #(
    parameter int AW      = 16,
    parameter int BASE    = 'h100,
    parameter int STRIDE  = 16,
    parameter int ENTRIES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] addr
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [IW-1:0] idx;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            if (ptr_q.idx == IW'(ENTRIES - 1)) begin
                ptr_d.addr = AW'(BASE);
                ptr_d.idx  = '0;
            end else begin
                ptr_d.addr = ptr_q.addr + AW'(STRIDE);
                ptr_d.idx  = ptr_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q.addr <= AW'(BASE);
            ptr_q.idx  <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign addr = ptr_q.addr;
endmodule

// File: rtl/txdesc_evt_flags.sv
module txdesc_evt_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_set,
    input  logic [N-1:0] evt_clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_d, flags_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        assign flags_d[i] = evt_set[i] | (flags_q[i] & ~evt_clr[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/txdesc_fsm.sv
module txdesc_fsm
    import txdesc_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_poll,
    input  logic              jab_abort,
    input  logic              frame_done,
    input  logic [STAT_W-1:0] frame_stat,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    output logic              frame_go,
    output logic              adv,
    output logic [EVT_N-1:0]  evt_set,
    output logic [2:0]        proc_state
);
    typedef struct packed {
        tx_state_e         state;
        logic              stop_pend;
        logic              err;
        logic [STAT_W-1:0] stat;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        frame_go  = 1'b0;
        adv       = 1'b0;
        evt_set   = '0;
        mem_wdata = '0;
        mem_wdata[OWN_BIT]      = 1'b0;
        mem_wdata[ERR_BIT]      = r_q.err;
        mem_wdata[STAT_W-1:0]   = r_q.stat;

        if (cmd_stop && r_q.state != TX_STOPPED) r_d.stop_pend = 1'b1;

        case (r_q.state)
            TX_STOPPED: begin
                r_d.stop_pend = 1'b0;
                if (cmd_start) r_d.state = TX_FETCH;
            end
            TX_FETCH: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    if (mem_rdata[OWN_BIT]) begin
                        r_d.state = TX_WAIT;
                        frame_go  = 1'b1;
                    end else begin
                        r_d.state = TX_SUSPEND;
                        evt_set[EVT_UNAVAIL] = 1'b1;
                    end
                end
            end
            TX_WAIT: begin
                if (jab_abort) begin
                    r_d.state = TX_CLOSE;
                    r_d.err   = 1'b1;
                    r_d.stat  = '0;
                end else if (frame_done) begin
                    r_d.state = TX_CLOSE;
                    r_d.err   = 1'b0;
                    r_d.stat  = frame_stat;
                end
            end
            TX_CLOSE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    adv = 1'b1;
                    evt_set[EVT_DONE] = ~r_q.err;
                    if (r_q.err || r_d.stop_pend) begin
                        r_d.state     = TX_STOPPED;
                        r_d.stop_pend = 1'b0;
                        evt_set[EVT_STOPPED] = 1'b1;
                    end else begin
                        r_d.state = TX_FETCH;
                    end
                end
            end
            TX_SUSPEND: begin
                if (r_d.stop_pend) begin
                    r_d.state     = TX_STOPPED;
                    r_d.stop_pend = 1'b0;
                    evt_set[EVT_STOPPED] = 1'b1;
                end else if (cmd_poll) begin
                    r_d.state = TX_FETCH;
                end
            end
            default: r_d.state = TX_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state     <= TX_STOPPED;
            r_q.stop_pend <= 1'b0;
            r_q.err       <= 1'b0;
            r_q.stat      <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign proc_state = r_q.state;
endmodule

// File: rtl/txdesc_owner_ctrl.sv
module txdesc_owner_ctrl
    import txdesc_pkg::*;
#(
    parameter int AW      = 16,
    parameter int STAT_W  = 16,
    parameter int BASE    = 'h100,
    parameter int STRIDE  = 16,
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_poll,
    input  logic              jab_abort,
    input  logic              frame_done,
    input  logic [STAT_W-1:0] frame_stat,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              frame_go,
    output logic [2:0]        proc_state,
    output logic [EVT_N-1:0]  evt_flags,
    input  logic [EVT_N-1:0]  evt_clr
);
    logic             adv;
    logic [EVT_N-1:0] evt_set;

    txdesc_fsm #(.STAT_W(STAT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .cmd_poll   (cmd_poll),
        .jab_abort  (jab_abort),
        .frame_done (frame_done),
        .frame_stat (frame_stat),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .frame_go   (frame_go),
        .adv        (adv),
        .evt_set    (evt_set),
        .proc_state (proc_state)
    );

    txdesc_ring_ptr #(
        .AW(AW), .BASE(BASE), .STRIDE(STRIDE), .ENTRIES(ENTRIES)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .addr  (mem_addr)
    );

    txdesc_evt_flags #(.N(EVT_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_set (evt_set),
        .evt_clr (evt_clr),
        .flags   (evt_flags)
    );
endmodule

// File: rtl/txdesc_owner_ctrl_chk.sv
module txdesc_owner_ctrl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_poll,
    input logic          jab_abort,
    input logic          frame_done,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          frame_go,
    input logic [2:0]    proc_state,
    input logic [2:0]    evt_flags
);
    // R11
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proc_state inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd6});

    // R11
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6
    own_returned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]);

    // R3
    go_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |=> (proc_state == 3'd2));

    // R4
    unavail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flags[1]) |-> (proc_state == 3'd6));

    // R9
    stopped_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flags[2]) |-> (proc_state == 3'd0));

    // R5
    poll_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_state == 3'd2 && cmd_poll && !jab_abort && !frame_done) |=> (proc_state == 3'd2));
endmodule

bind txdesc_owner_ctrl txdesc_owner_ctrl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_poll   (cmd_poll),
    .jab_abort  (jab_abort),
    .frame_done (frame_done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .frame_go   (frame_go),
    .proc_state (proc_state),
    .evt_flags  (evt_flags)
);

// File: tb/txdesc_owner_ctrl_bench.sv
module txdesc_owner_ctrl_bench;
    localparam int AW = 16;
    localparam int BASE = 'h100;
    localparam int STRIDE = 16;
    localparam int ENTRIES = 4;
    localparam logic [31:0] OWNED = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 0, cmd_stop = 0, cmd_poll = 0, jab_abort = 0, frame_done = 0;
    logic [15:0] frame_stat = '0;
    logic        mem_req, mem_we, frame_go;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [2:0]  proc_state, evt_flags;
    logic [2:0]  evt_clr = '0;

    int checks = 0;
    int errors = 0;
    int go_cnt = 0;
    logic [31:0] ring [ENTRIES];
    logic [AW-1:0] exp_addr_q [$];
    logic [31:0]   exp_data_q [$];
    string         exp_tag_q [$];

    always #5 clk = ~clk;

    txdesc_owner_ctrl u_txdesc_owner_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_poll(cmd_poll), .jab_abort(jab_abort), .frame_done(frame_done),
        .frame_stat(frame_stat), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .frame_go(frame_go), .proc_state(proc_state),
        .evt_flags(evt_flags), .evt_clr(evt_clr)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int idx_of(logic [AW-1:0] a);
        return int'((a - AW'(BASE)) / AW'(STRIDE)) % ENTRIES;
    endfunction

    // driver side of the scoreboard
    task automatic push_exp(logic [AW-1:0] a, logic [31:0] d, string tag);
        exp_addr_q.push_back(a);
        exp_data_q.push_back(d);
        exp_tag_q.push_back(tag);
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_ack) mem_ack <= 1'b0;
        else if (mem_req) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                ring[idx_of(mem_addr)] = mem_wdata;
                if (exp_addr_q.size() == 0) begin
                    chk(0, "R6 unexpected write-back", {16'h0, mem_addr}, 32'h0);
                end else begin
                    string t;
                    logic [AW-1:0] ea;
                    logic [31:0] ed;
                    ea = exp_addr_q.pop_front();
                    ed = exp_data_q.pop_front();
                    t  = exp_tag_q.pop_front();
                    chk(mem_addr == ea, {t, " write-back address"}, {16'h0, mem_addr}, {16'h0, ea});
                    chk(mem_wdata == ed, {t, " write-back word"}, mem_wdata, ed);
                end
            end else begin
                mem_rdata <= ring[idx_of(mem_addr)];
            end
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && frame_go) go_cnt++;
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic pulse_start(); cmd_start = 1; tick(); cmd_start = 0; endtask
    task automatic pulse_stop();  cmd_stop  = 1; tick(); cmd_stop  = 0; endtask
    task automatic pulse_poll();  cmd_poll  = 1; tick(); cmd_poll  = 0; endtask
    task automatic pulse_abort(); jab_abort = 1; tick(); jab_abort = 0; endtask
    task automatic pulse_clr(logic [2:0] m); evt_clr = m; tick(); evt_clr = '0; endtask
    task automatic pulse_done(logic [15:0] s);
        frame_stat = s; frame_done = 1; tick(); frame_done = 0;
    endtask

    task automatic wait_state(logic [2:0] s, string tag);
        int n;
        n = 0;
        while (proc_state != s && n < 50) begin
            tick();
            n++;
        end
        chk(proc_state == s, tag, {29'h0, proc_state}, {29'h0, s});
    endtask

    initial begin
        #(10 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) ring[i] = 32'h0;
        ring[0] = OWNED;
        ring[1] = OWNED;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk(proc_state == 3'd0, "R1 state", {29'h0, proc_state}, 0);
        chk(evt_flags == 3'd0, "R1 flags", {29'h0, evt_flags}, 0);
        chk(!mem_req, "R1 no request", {31'h0, mem_req}, 0);
        chk(mem_addr == AW'(BASE), "R1 address", {16'h0, mem_addr}, BASE);

        // R5 poll while Stopped is ignored
        pulse_poll();
        tick();
        chk(proc_state == 3'd0 && !mem_req, "R5 poll in Stopped", {29'h0, proc_state}, 0);

        // R2/R3 start and first owned descriptor
        pulse_start();
        wait_state(3'd2, "R2 start fetches owned descriptor");
        chk(go_cnt == 1, "R3 frame_go single pulse", go_cnt, 1);
        pulse_poll();
        chk(proc_state == 3'd2, "R5 poll in Waiting ignored", {29'h0, proc_state}, 2);

        // R6 completion write-back
        push_exp(AW'(BASE), 32'h0000_1234, "R6");
        pulse_done(16'h1234);
        wait_state(3'd2, "R6 next descriptor fetched");
        chk(evt_flags == 3'b001, "R6 complete flag", {29'h0, evt_flags}, 1);
        chk(mem_addr == AW'(BASE + STRIDE), "R7 advance", {16'h0, mem_addr}, BASE + STRIDE);

        push_exp(AW'(BASE + STRIDE), 32'h0000_00AB, "R6");
        pulse_done(16'h00AB);
        // R4 host-owned entry suspends
        wait_state(3'd6, "R4 suspend on host-owned");
        chk(evt_flags == 3'b011, "R4 unavailable flag", {29'h0, evt_flags}, 3);
        chk(mem_addr == AW'(BASE + 2 * STRIDE), "R7 address at suspend", {16'h0, mem_addr}, BASE + 2 * STRIDE);

        // R10 write-one-to-clear
        pulse_clr(3'b001);
        chk(evt_flags == 3'b010, "R10 clear bit 0", {29'h0, evt_flags}, 2);
        pulse_clr(3'b100);
        chk(evt_flags == 3'b010, "R10 clear of zero flag", {29'h0, evt_flags}, 2);

        // R2 start ignored while Suspended
        pulse_start();
        tick();
        chk(proc_state == 3'd6 && !mem_req, "R2 start outside Stopped", {29'h0, proc_state}, 6);

        // R5 poll resumes, R7 wrap
        ring[2] = OWNED;
        ring[3] = OWNED;
        ring[0] = OWNED;
        pulse_poll();
        wait_state(3'd2, "R5 poll resumes");
        chk(mem_addr == AW'(BASE + 2 * STRIDE), "R5 same address", {16'h0, mem_addr}, BASE + 2 * STRIDE);
        push_exp(AW'(BASE + 2 * STRIDE), 32'h0000_0003, "R6");
        pulse_done(16'h0003);
        wait_state(3'd2, "R7 fourth entry");
        push_exp(AW'(BASE + 3 * STRIDE), 32'h0000_0004, "R6");
        pulse_done(16'h0004);
        wait_state(3'd2, "R7 wrapped fetch");
        chk(mem_addr == AW'(BASE), "R7 wrap to base", {16'h0, mem_addr}, BASE);

        // R8 jabber abort
        push_exp(AW'(BASE), 32'h4000_0000, "R8");
        pulse_abort();
        wait_state(3'd0, "R8 abort stops");
        chk(evt_flags == 3'b111, "R8 flags after abort", {29'h0, evt_flags}, 7);
        chk(mem_addr == AW'(BASE + STRIDE), "R8 address advanced", {16'h0, mem_addr}, BASE + STRIDE);
        pulse_clr(3'b111);
        chk(evt_flags == 3'b000, "R10 clear all", {29'h0, evt_flags}, 0);

        // R9 stop while Suspended (entry 1 now host-owned)
        pulse_start();
        wait_state(3'd6, "R9 suspended before stop");
        pulse_stop();
        chk(proc_state == 3'd0, "R9 stop from Suspended", {29'h0, proc_state}, 0);
        chk(evt_flags == 3'b110, "R9 stopped flag", {29'h0, evt_flags}, 6);

        // R9 stop held until descriptor closes
        ring[1] = OWNED;
        pulse_clr(3'b111);
        pulse_start();
        wait_state(3'd2, "R9 waiting");
        pulse_stop();
        tick();
        chk(proc_state == 3'd2, "R9 stop held in flight", {29'h0, proc_state}, 2);
        push_exp(AW'(BASE + STRIDE), 32'h0000_0055, "R9");
        pulse_done(16'h0055);
        wait_state(3'd0, "R9 stopped after close");
        chk(evt_flags == 3'b101, "R9 flags after close", {29'h0, evt_flags}, 5);
        chk(mem_addr == AW'(BASE + 2 * STRIDE), "R9 address", {16'h0, mem_addr}, BASE + 2 * STRIDE);

        // R10 set wins over clear
        ring[2] = 32'h0;
        pulse_clr(3'b111);
        pulse_start();
        while (!mem_ack) tick();
        evt_clr = 3'b010;
        tick();
        evt_clr = '0;
        chk(proc_state == 3'd6, "R4 suspend", {29'h0, proc_state}, 6);
        chk(evt_flags[1] == 1'b1, "R10 set beats clear", {31'h0, evt_flags[1]}, 1);

        chk(exp_addr_q.size() == 0, "R6 all write-backs seen", exp_addr_q.size(), 0);
        chk(go_cnt == 6, "R3 frame_go count", go_cnt, 6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule